// File: doc/BRIEF.md
# Bit-Serial Adder

This block adds two unsigned operands by reusing a single full adder once per clock. On a start pulse the two operands are captured into right-shifting registers and the stored carry is cleared. On each following cycle the least significant bits of both registers and the stored carry enter the full adder. The sum bit enters the top of the first operand register, and the carry flip-flop takes its next value.

After as many shift cycles as the operand has bits, the first operand register holds the sum. The block then raises `done`, stops shifting and shows the final carry on `carry_out` until the next start. The operand width is a parameter whose intended value is 4. A start pulse while a run is in progress abandons that run and begins a new one with the operands on the inputs.

Top module: `serial_adder4`

## Requirements
- R1: After reset, `busy`, `done`, `carry_out` and `sum` are all 0.
- R2: A clock edge with `start` high captures `a_in` and `b_in` and clears the carry. From the next cycle `busy` is 1 and `done` is 0.
- R3: Each shift cycle forms x XOR y XOR c from the low bits x, y of the operand registers and the stored carry c. That bit enters the most significant position of the first operand register, which shifts right. The second operand register shifts right with 0 entering at its top. After 4 shifts `sum` equals (a_in + b_in) mod 16.
- R4: The stored carry becomes 1 when x and y are both 1, becomes 0 when both are 0, and otherwise keeps its value. Once `done` is 1, `carry_out` equals bit 4 of a_in + b_in. While `done` is 0, `carry_out` is 0.
- R5: `busy` stays 1 for exactly 4 cycles after the load edge. `done` rises on the edge that ends the 4th shift. `busy` and `done` are never both 1.
- R6: While `done` is 1 and `start` is low, `done`, `sum` and `carry_out` stay unchanged.
- R7: `start` during a run discards that run and restarts with the new operands. The full 4 shift cycles follow.
- R8: `a_in` and `b_in` have no effect while `start` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Load operands and begin an addition |
| a_in | input | 4 | First operand, parallel |
| b_in | input | 4 | Second operand, parallel |
| busy | output | 1 | Addition in progress |
| done | output | 1 | Result valid |
| sum | output | 4 | First operand register; holds the sum when done |
| carry_out | output | 1 | Final carry, valid while done |

## Verification
The start pulse is driven for one cycle. The load takes effect on the edge that sees it, so `busy` is checked at the following falling edge. The next three falling edges must still show `busy` without `done`. The result, final carry and `done` are due at the fourth falling edge after the load, and every sample is taken at a falling edge so it lands there exactly. Expected sums and carries come from plain integer addition in a bench function. For restarts and operand changes during a run, the expected value is tied to the operands present at the last start edge.

// File: rtl/serial_adder4.sv
module serial_adder4 #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] sum,
  output logic         carry_out
);
  localparam int CW = $clog2(W + 1);
  localparam logic [CW-1:0] LAST = CW'(W - 1);

  logic [W-1:0]  a_q, b_q;
  logic          c_q;
  logic [CW-1:0] cnt_q;
  logic          busy_q, done_q;

  logic x, y, s_bit;
  assign x     = a_q[0];
  assign y     = b_q[0];
  assign s_bit = x ^ y ^ c_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q    <= '0;
      b_q    <= '0;
      c_q    <= 1'b0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else if (start) begin
      a_q    <= a_in;
      b_q    <= b_in;
      c_q    <= 1'b0;
      cnt_q  <= '0;
      busy_q <= 1'b1;
      done_q <= 1'b0;
    end else if (busy_q) begin
      a_q <= {s_bit, a_q[W-1:1]};
      b_q <= {1'b0, b_q[W-1:1]};
      case ({x & y, ~x & ~y})
        2'b10:   c_q <= 1'b1;
        2'b01:   c_q <= 1'b0;
        default: c_q <= c_q;
      endcase
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign sum       = a_q;
  assign carry_out = done_q & c_q;

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && !done && !carry_out);
  p_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));
  p_carry_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start && x && y |=> c_q);
  p_carry_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start && !x && !y |=> !c_q);
  p_sumbit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !start |=> sum[W-1] == ($past(x) ^ $past(y) ^ $past(c_q)));
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(sum) && $stable(carry_out));
  p_nocarry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> !carry_out);
  p_finish_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) && !$past(start) |-> done);
endmodule

// File: tb/serial_adder4_tb.sv
module serial_adder4_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [3:0] a_in = '0, b_in = '0;
  logic       busy, done, carry_out;
  logic [3:0] sum;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  serial_adder4 #(.W(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in), .b_in(b_in),
    .busy(busy), .done(done), .sum(sum), .carry_out(carry_out)
  );

  function automatic logic [4:0] ref_add(input logic [3:0] a, input logic [3:0] b);
    return {1'b0, a} + {1'b0, b};
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic pulse(input logic [3:0] a, input logic [3:0] b);
    @(negedge clk);
    start = 1'b1; a_in = a; b_in = b;
    @(negedge clk);
    start = 1'b0;
  endtask

  // after pulse: load edge passed; wait the four shift edges and check
  task automatic finish_and_check(input logic [3:0] a, input logic [3:0] b);
    logic [4:0] e;
    e = ref_add(a, b);
    chk("R2 busy after load", {6'd0, busy, done}, 8'h02);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R5 busy during shifts", {6'd0, busy, done}, 8'h02);
      chk("R4 carry_out low before done", {7'd0, carry_out}, 8'h00);
    end
    @(negedge clk);
    chk("R5 done after 4 shifts", {6'd0, busy, done}, 8'h01);
    chk("R3 sum", {4'd0, sum}, {4'd0, e[3:0]});
    chk("R4 carry_out", {7'd0, carry_out}, {7'd0, e[4]});
  endtask

  task automatic add(input logic [3:0] a, input logic [3:0] b);
    pulse(a, b);
    finish_and_check(a, b);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [4:0] e;
    void'($urandom(32'd1234));
    repeat (2) @(negedge clk);
    chk("R1 reset state", {2'd0, busy, done, carry_out, 3'd0}, 8'h00);
    chk("R1 reset sum", {4'd0, sum}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {6'd0, busy, done}, 8'h00);

    add(4'd0, 4'd0);
    add(4'hF, 4'hF);
    add(4'hF, 4'h1);
    add(4'h8, 4'h8);
    add(4'h5, 4'hA);
    add(4'h7, 4'h1);

    // R6: result holds while idle, even with inputs moving (R8)
    e = ref_add(4'h7, 4'h1);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      a_in = 4'($urandom); b_in = 4'($urandom);
      chk("R6 done held", {7'd0, done}, 8'h01);
      chk("R6 sum held", {3'd0, carry_out, sum}, {3'd0, e});
    end

    // R8: operand inputs change mid-run without start
    pulse(4'h9, 4'h3);
    a_in = 4'hF; b_in = 4'hF;
    finish_and_check(4'h9, 4'h3);

    // R7: restart during a run
    pulse(4'hE, 4'hE);
    @(negedge clk);
    pulse(4'h2, 4'h3);
    finish_and_check(4'h2, 4'h3);

    // R3 R4 random operands
    for (int i = 0; i < 60; i++) begin
      logic [3:0] ra, rb;
      ra = 4'($urandom); rb = 4'($urandom);
      add(ra, rb);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule